// File: doc/BRIEF.md
# Two-Class Queue Request Scheduler

This block sits next to a set of routing queues and, once per scheduling period, nominates a single queue to be sent next. Each queue has two sub-queues. One carries guaranteed-bandwidth traffic and the other carries best-effort traffic. The block receives a non-empty flag for every sub-queue, a service period for each guaranteed sub-queue, and a weight for each best-effort sub-queue. The nomination leaves the block as a request made of a queue index and a class bit. An arbiter elsewhere accepts the request by raising `req_ready`. The block then reports the transfer one cycle later on the `xfer_*` pins.

Guaranteed traffic is shaped by a virtual clock. Each guaranteed sub-queue carries a next-eligible timestamp, measured in scheduling periods. A guaranteed sub-queue that is eligible always wins over best-effort traffic. Best-effort sub-queues share the remaining periods by weighted round robin, using per-queue credit counters.

The request interface follows valid/ready rules. Once `req_valid` is high, the index and class stay frozen until the cycle in which `req_ready` is sampled high. `req_ready` has no effect while no request is pending. No scheduler state changes until a grant arrives. A period tick that arrives while a request is pending still advances the period count, but it produces no new selection.

Top module: `rqs_sched`

## Requirements
- R1: After reset, `req_valid` and `xfer_valid` are low, the period count is 0, every guaranteed timestamp is 0 and every best-effort credit is 0.
- R2: A new request is raised only in the cycle after a cycle in which `period_tick` was high, no request was pending, and some sub-queue was selectable. `period_tick` increments the period count whether or not a request is raised.
- R3: When any guaranteed sub-queue is eligible, the request carries `req_gbw`=1, and no best-effort sub-queue is chosen.
- R4: Among eligible guaranteed sub-queues, the one with the earliest timestamp is chosen. Equal timestamps go to the lowest index.
- R5: A guaranteed sub-queue is eligible when its non-empty flag is set and its timestamp is not later than the period count, compared modulo 2^TS_W as a signed difference. On a grant, its timestamp becomes max(timestamp, period count) + its service period, taken from `gbw_period` bits [q*PER_W +: PER_W].
- R6: With no guaranteed sub-queue eligible, a non-empty best-effort sub-queue with nonzero credit is chosen. The search runs in circular order, starting at the index after the last granted best-effort queue (index 0 after reset). If no non-empty sub-queue has credit, every credit is treated as reloaded from its weight, taken from `be_weight` bits [q*WT_W +: WT_W]. On a grant the reload is committed and the chosen credit is decremented.
- R7: In the cycle after `req_valid` and `req_ready` are both high, `xfer_valid` pulses for one cycle, carrying the granted index and class. In every other cycle it is low.
- R8: While `req_valid` is high and `req_ready` is low, the index and class hold steady and `req_valid` stays high.
- R9: A best-effort sub-queue whose weight is 0 is never chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_tick | input | 1 | Marks one scheduling period; advances the period count |
| gbw_ne | input | NQ | Guaranteed sub-queue non-empty flags |
| be_ne | input | NQ | Best-effort sub-queue non-empty flags |
| gbw_period | input | NQ*PER_W | Service period per guaranteed sub-queue |
| be_weight | input | NQ*WT_W | Weight per best-effort sub-queue |
| req_valid | output | 1 | Request pending |
| req_ready | input | 1 | Grant from the arbiter |
| req_qid | output | QW | Requested queue index |
| req_gbw | output | 1 | Requested class: 1 guaranteed, 0 best effort |
| xfer_valid | output | 1 | Granted cell moves this cycle |
| xfer_qid | output | QW | Index of the cell being moved |
| xfer_gbw | output | 1 | Class of the cell being moved |

## Verification
The bench goes after several corner cases, each of which has a distinct failure.
- Timestamp ties at reset: if ties are broken toward the wrong index, a high-numbered queue is served first.
- Timestamp update on a grant: a design that adds the period to a stale timestamp instead of to max(timestamp, now) lets an idle guaranteed queue burst through several back-to-back grants.
- Credit exhaustion: if the reload is missed or applied early, best-effort traffic stalls or ignores its weights.
- Zero weights: a zero weight must never be served.
- Grants outside the handshake: a grant while idle must do nothing, and a tick during a pending request must not replace the request under the arbiter or move state.

// File: rtl/rqs_pkg.sv
package rqs_pkg;
  typedef enum logic {
    CLS_BE  = 1'b0,
    CLS_GBW = 1'b1
  } cls_e;
endpackage

// File: rtl/rqs_gbw_shaper.sv
module rqs_gbw_shaper #(
  parameter int NQ    = 4,
  parameter int TS_W  = 16,
  parameter int PER_W = 8,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TS_W-1:0]       now,
  input  logic [NQ-1:0]         ne,
  input  logic [NQ*PER_W-1:0]   period_cfg,
  input  logic                  upd,
  input  logic [QW-1:0]         upd_q,
  output logic                  pick_valid,
  output logic [QW-1:0]         pick_q
);
  logic [TS_W-1:0] ts_q [NQ];
  logic [NQ-1:0]   elig;
  logic [TS_W-1:0] best_ts;
  logic [TS_W-1:0] diff;

  // eligible when now - ts is non-negative as a signed value
  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      diff    = now - ts_q[q];
      elig[q] = ne[q] && !diff[TS_W-1];
    end
  end

  // earliest timestamp wins; strict compare keeps the lowest index on ties
  always_comb begin
    logic [TS_W-1:0] d;
    pick_valid = 1'b0;
    pick_q     = '0;
    best_ts    = '0;
    for (int q = 0; q < NQ; q++) begin
      d = ts_q[q] - best_ts;
      if (elig[q] && (!pick_valid || d[TS_W-1])) begin
        pick_valid = 1'b1;
        pick_q     = QW'(q);
        best_ts    = ts_q[q];
      end
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_ts
    logic [TS_W-1:0] lag;
    logic [TS_W-1:0] base;
    assign lag  = now - ts_q[g];
    assign base = lag[TS_W-1] ? ts_q[g] : now;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ts_q[g] <= '0;
      end else if (upd && (upd_q == QW'(g))) begin
        ts_q[g] <= base + TS_W'(period_cfg[g*PER_W +: PER_W]);
      end
    end
  end
endmodule

// File: rtl/rqs_be_wrr.sv
module rqs_be_wrr #(
  parameter int NQ   = 4,
  parameter int WT_W = 4,
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NQ-1:0]       ne,
  input  logic [NQ*WT_W-1:0]  weight_cfg,
  input  logic                upd,
  input  logic [QW-1:0]       upd_q,
  input  logic                upd_reload,
  output logic                pick_valid,
  output logic [QW-1:0]       pick_q,
  output logic                pick_reload
);
  logic [WT_W-1:0] cred_q [NQ];
  logic [QW-1:0]   ptr_q;
  logic [NQ-1:0]   live;
  logic [NQ-1:0]   cand;

  always_comb begin
    for (int q = 0; q < NQ; q++) live[q] = ne[q] && (cred_q[q] != '0);
    pick_reload = ~|live;
    for (int q = 0; q < NQ; q++) begin
      cand[q] = pick_reload ? (ne[q] && (weight_cfg[q*WT_W +: WT_W] != '0)) : live[q];
    end
  end

  // circular search starting at the pointer
  always_comb begin
    int idx;
    pick_valid = 1'b0;
    pick_q     = '0;
    for (int k = 0; k < NQ; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= NQ) idx = idx - NQ;
      if (!pick_valid && cand[idx]) begin
        pick_valid = 1'b1;
        pick_q     = QW'(idx);
      end
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_cred
    logic [WT_W-1:0] start;
    assign start = upd_reload ? weight_cfg[g*WT_W +: WT_W] : cred_q[g];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cred_q[g] <= '0;
      end else if (upd) begin
        if (upd_q == QW'(g)) begin
          cred_q[g] <= (start != '0) ? start - 1'b1 : '0;
        end else if (upd_reload) begin
          cred_q[g] <= start;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (upd) begin
      ptr_q <= (int'(upd_q) == NQ-1) ? '0 : upd_q + 1'b1;
    end
  end
endmodule

// File: rtl/rqs_sched.sv
module rqs_sched #(
  parameter int NQ    = 4,
  parameter int TS_W  = 16,
  parameter int PER_W = 8,
  parameter int WT_W  = 4,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                period_tick,
  input  logic [NQ-1:0]       gbw_ne,
  input  logic [NQ-1:0]       be_ne,
  input  logic [NQ*PER_W-1:0] gbw_period,
  input  logic [NQ*WT_W-1:0]  be_weight,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [QW-1:0]       req_qid,
  output logic                req_gbw,
  output logic                xfer_valid,
  output logic [QW-1:0]       xfer_qid,
  output logic                xfer_gbw
);
  import rqs_pkg::*;

  logic [TS_W-1:0] now_q;
  logic            grant;
  logic            gbw_pick_valid;
  logic [QW-1:0]   gbw_pick_q;
  logic            be_pick_valid;
  logic [QW-1:0]   be_pick_q;
  logic            be_pick_reload;
  logic            req_reload_q;
  cls_e            cls_sel;

  assign grant   = req_valid && req_ready;
  assign cls_sel = gbw_pick_valid ? CLS_GBW : CLS_BE;

  rqs_gbw_shaper #(.NQ(NQ), .TS_W(TS_W), .PER_W(PER_W)) u_gbw (
    .clk        (clk),
    .rst_n      (rst_n),
    .now        (now_q),
    .ne         (gbw_ne),
    .period_cfg (gbw_period),
    .upd        (grant && req_gbw),
    .upd_q      (req_qid),
    .pick_valid (gbw_pick_valid),
    .pick_q     (gbw_pick_q)
  );

  rqs_be_wrr #(.NQ(NQ), .WT_W(WT_W)) u_be (
    .clk         (clk),
    .rst_n       (rst_n),
    .ne          (be_ne),
    .weight_cfg  (be_weight),
    .upd         (grant && !req_gbw),
    .upd_q       (req_qid),
    .upd_reload  (req_reload_q),
    .pick_valid  (be_pick_valid),
    .pick_q      (be_pick_q),
    .pick_reload (be_pick_reload)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q <= '0;
    end else if (period_tick) begin
      now_q <= now_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid    <= 1'b0;
      req_qid      <= '0;
      req_gbw      <= 1'b0;
      req_reload_q <= 1'b0;
    end else if (!req_valid) begin
      if (period_tick && (gbw_pick_valid || be_pick_valid)) begin
        req_valid    <= 1'b1;
        req_qid      <= gbw_pick_valid ? gbw_pick_q : be_pick_q;
        req_gbw      <= (cls_sel == CLS_GBW);
        req_reload_q <= !gbw_pick_valid && be_pick_reload;
      end
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_valid <= 1'b0;
      xfer_qid   <= '0;
      xfer_gbw   <= 1'b0;
    end else begin
      xfer_valid <= grant;
      if (grant) begin
        xfer_qid <= req_qid;
        xfer_gbw <= req_gbw;
      end
    end
  end
endmodule

// File: rtl/rqs_sched_chk.sv
module rqs_sched_chk #(
  parameter int QW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          period_tick,
  input logic          req_valid,
  input logic          req_ready,
  input logic [QW-1:0] req_qid,
  input logic          req_gbw,
  input logic          xfer_valid,
  input logic [QW-1:0] xfer_qid,
  input logic          xfer_gbw,
  input logic          gbw_any
);
  a_r8_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_qid) && $stable(req_gbw)));

  a_r7_xfer_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (xfer_valid && xfer_qid == $past(req_qid) && xfer_gbw == $past(req_gbw)));

  a_r7_no_spurious_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !xfer_valid);

  a_r2_issue_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(period_tick));

  a_r3_gbw_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && !req_gbw) |-> !$past(gbw_any));
endmodule

bind rqs_sched rqs_sched_chk #(.QW(QW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .period_tick (period_tick),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_qid     (req_qid),
  .req_gbw     (req_gbw),
  .xfer_valid  (xfer_valid),
  .xfer_qid    (xfer_qid),
  .xfer_gbw    (xfer_gbw),
  .gbw_any     (gbw_pick_valid)
);

// File: tb/rqs_sched_test.sv
module rqs_sched_test;
  localparam int NQ = 4, TS_W = 16, PER_W = 8, WT_W = 4, QW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_tick = 1'b0;
  logic [NQ-1:0] gbw_ne = '0, be_ne = '0;
  logic [NQ*PER_W-1:0] gbw_period;
  logic [NQ*WT_W-1:0] be_weight;
  logic req_valid, req_ready = 1'b0, req_gbw, xfer_valid, xfer_gbw;
  logic [QW-1:0] req_qid, xfer_qid;

  logic [PER_W-1:0] per [NQ];
  logic [WT_W-1:0]  wt [NQ];
  always_comb for (int q = 0; q < NQ; q++) begin
    gbw_period[q*PER_W +: PER_W] = per[q];
    be_weight[q*WT_W +: WT_W]    = wt[q];
  end

  always #5 clk = ~clk;

  rqs_sched #(.NQ(NQ), .TS_W(TS_W), .PER_W(PER_W), .WT_W(WT_W)) uut (
    .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .gbw_ne(gbw_ne), .be_ne(be_ne),
    .gbw_period(gbw_period), .be_weight(be_weight), .req_valid(req_valid), .req_ready(req_ready),
    .req_qid(req_qid), .req_gbw(req_gbw), .xfer_valid(xfer_valid), .xfer_qid(xfer_qid),
    .xfer_gbw(xfer_gbw));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic [TS_W-1:0] m_now, m_ts [NQ];
  logic [WT_W-1:0] m_cred [NQ];
  int m_ptr;
  logic m_valid, m_gbw, m_reload, m_xv, m_xg;
  int m_qid, m_xq;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit later(logic [TS_W-1:0] a, logic [TS_W-1:0] b);
    logic [TS_W-1:0] d = b - a;
    return d[TS_W-1];
  endfunction

  task automatic model_reset();
    m_now = '0; m_ptr = 0; m_valid = 0; m_gbw = 0; m_reload = 0; m_xv = 0; m_xg = 0;
    m_qid = 0; m_xq = 0;
    for (int q = 0; q < NQ; q++) begin m_ts[q] = '0; m_cred[q] = '0; end
  endtask

  task automatic model_step();
    if (m_valid && req_ready) begin
      if (m_gbw) begin
        m_ts[m_qid] = (later(m_ts[m_qid], m_now) ? m_ts[m_qid] : m_now) + TS_W'(per[m_qid]);
      end else begin
        logic [WT_W-1:0] st = m_reload ? wt[m_qid] : m_cred[m_qid];
        if (m_reload) for (int q = 0; q < NQ; q++) m_cred[q] = wt[q];
        m_cred[m_qid] = (st != 0) ? st - 1'b1 : '0;
        m_ptr = (m_qid + 1) % NQ;
      end
      m_xv = 1; m_xq = m_qid; m_xg = m_gbw; m_valid = 0;
    end else begin
      m_xv = 0;
      if (!m_valid && period_tick) begin
        bit gv = 0; int gq = 0; bit any_live = 0;
        for (int q = 0; q < NQ; q++)
          if (gbw_ne[q] && !later(m_ts[q], m_now) && (!gv || later(m_ts[gq], m_ts[q]))) begin
            gv = 1; gq = q;
          end
        if (gv) begin
          m_valid = 1; m_qid = gq; m_gbw = 1; m_reload = 0;
        end else begin
          for (int q = 0; q < NQ; q++) if (be_ne[q] && m_cred[q] != 0) any_live = 1;
          for (int k = 0; k < NQ; k++) begin
            int i = (m_ptr + k) % NQ;
            bit ok = any_live ? (be_ne[i] && m_cred[i] != 0) : (be_ne[i] && wt[i] != 0);
            if (!m_valid && ok) begin
              m_valid = 1; m_qid = i; m_gbw = 0; m_reload = !any_live;
            end
          end
        end
      end
    end
    if (period_tick) m_now = m_now + 1'b1;
  endtask

  task automatic compare();
    chk("R2 req_valid", int'(req_valid), int'(m_valid));
    if (m_valid) begin
      chk("R3 req_gbw", int'(req_gbw), int'(m_gbw));
      chk(m_gbw ? "R4/R5 req_qid" : "R6/R9 req_qid", int'(req_qid), m_qid);
    end
    chk("R7 xfer_valid", int'(xfer_valid), int'(m_xv));
    if (m_xv) begin
      chk("R7 xfer_qid", int'(xfer_qid), m_xq);
      chk("R7 xfer_gbw", int'(xfer_gbw), int'(m_xg));
    end
  endtask

  task automatic cyc(bit tk, logic [NQ-1:0] g, logic [NQ-1:0] b, bit rd);
    period_tick = tk; gbw_ne = g; be_ne = b; req_ready = rd;
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic rand_phase(int cycles, int gden);
    for (int i = 0; i < cycles; i++) begin
      logic [NQ-1:0] g, b;
      for (int q = 0; q < NQ; q++) begin
        g[q] = ($urandom % gden) == 0;
        b[q] = ($urandom % 2) == 0;
      end
      cyc(($urandom % 3) != 0, g, b, ($urandom % 3) == 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int q = 0; q < NQ; q++) begin per[q] = 8'd4; wt[q] = '0; end
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 req_valid after reset", int'(req_valid), 0);
    chk("R1 xfer_valid after reset", int'(xfer_valid), 0);

    // R9: all weights zero, best-effort queues non-empty: nothing requested
    cyc(1, 4'b0000, 4'b1111, 1'b0);
    cyc(1, 4'b0000, 4'b1111, 1'b1);
    chk("R9 zero weight no request", int'(req_valid), 0);
    // R2: guaranteed work present but no tick: nothing requested
    cyc(0, 4'b0110, 4'b0000, 1'b0);
    chk("R2 no tick no request", int'(req_valid), 0);
    // R4: equal timestamps (period count past them), lowest index wins
    cyc(1, 4'b0110, 4'b0000, 1'b0);
    chk("R4 tie goes to index 1", int'(req_qid), 1);
    // R8: hold while not granted even with a tick and changed inputs
    cyc(1, 4'b0001, 4'b1111, 1'b0);
    chk("R8 qid held", int'(req_qid), 1);
    cyc(0, 4'b0001, 4'b0000, 1'b1);
    cyc(0, 4'b0000, 4'b0000, 1'b0);
    chk("R7 xfer after grant", int'(xfer_qid), 1);

    per[0] = 8'd5; per[1] = 8'd9; per[2] = 8'd3; per[3] = 8'd12;
    wt[0] = 4'd3; wt[1] = 4'd1; wt[2] = 4'd0; wt[3] = 4'd2;
    rand_phase(3000, 8);

    per[0] = 8'd1; per[1] = 8'd2; per[2] = 8'd30; per[3] = 8'd7;
    wt[0] = 4'd1; wt[1] = 4'd4; wt[2] = 4'd1; wt[3] = 4'd15;
    rand_phase(3000, 3);

    // R5: a single guaranteed queue with a long period is served once per period
    per[2] = 8'd20;
    for (int i = 0; i < 60; i++) cyc(1, 4'b0100, 4'b0000, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule